// File: doc/BRIEF.md
# Character LCD Write Strobe Controller

This block turns one processor write into one complete write transaction on a character LCD panel of the common parallel type. The processor presents a 16-bit word. A single flag bit in that word chooses between data and command. The low bits of the word carry the value for the panel's data lines. When the block accepts the word, it latches the register-select level and the data-line value. It then moves through three timed phases: setup, enable high, and hold. A small down-counter sets the length of each phase, and a parameter gives that length in clock cycles. The panel's read/write line stays at write.

The write port uses valid/ready, but it never applies back-pressure in the usual sense. `wr_ready` is high exactly when no transaction is in flight. A word presented while `wr_ready` is low is dropped and is not held for later. Software has two choices: wait on `busy` (the inverse of `wr_ready`) before writing, or repeat the write after the transaction ends. Long panel delays, such as the wait after a clear command, are left to an external timer. The build-time parameter `BUS8` picks the panel wiring: 8 data lines, or 4 data lines with one nibble per write. In the 4-bit wiring, software sends the high nibble first and then the low nibble.

Top module: `lcd_strobe_ctrl`

## Requirements
- R1: After reset, `lcd_en`, `lcd_rs` and `busy` are 0, `lcd_db` is all zero, and `wr_ready` is 1.
- R2: A word is accepted at a rising clock edge where `wr_valid` and `wr_ready` are both 1. From the next cycle `busy` is 1 and `wr_ready` is 0.
- R3: `lcd_rs` takes bit `RS_BIT` (default 8) of the accepted word: 1 selects data, 0 selects command.
- R4: `lcd_db` takes the low `DB_W` bits of the accepted word. Word bits outside those bits and `RS_BIT` have no effect on any output.
- R5: `lcd_en` rises exactly `SETUP_CYC` cycles after the accepting edge, and `lcd_rs`/`lcd_db` already hold the new values during those cycles.
- R6: `lcd_en` stays high for exactly `HIGH_CYC` cycles, and exactly once per accepted word.
- R7: After `lcd_en` falls, `busy` stays 1 for exactly `HOLD_CYC` more cycles. `lcd_rs` and `lcd_db` do not change while `busy` is 1, and they keep their value until the next accepted word.
- R8: A word presented while `busy` is 1 is dropped: it produces no strobe and does not alter `lcd_rs` or `lcd_db`.
- R9: `lcd_rw` is 0 at all times (write).
- R10: With `BUS8`=0, `lcd_db` is 4 bits wide and carries bits 3:0 of each accepted word, with the same phase timing as the 8-bit wiring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Processor word present |
| wr_data | input | 16 | Processor word: data field in low bits, flag at `RS_BIT` |
| wr_ready | output | 1 | High when a word would be accepted |
| busy | output | 1 | Transaction in flight |
| lcd_rs | output | 1 | Panel register select (1 data, 0 command) |
| lcd_rw | output | 1 | Panel read/write, held at write (0) |
| lcd_en | output | 1 | Panel enable strobe |
| lcd_db | output | DB_W (8 or 4) | Panel data lines |

## Verification
Every output changes through one register after the accepting edge. So `busy`, `lcd_rs` and `lcd_db` are due one cycle after acceptance. `lcd_en` is due `SETUP_CYC` cycles after acceptance and falls `HIGH_CYC` cycles later, and `busy` clears `HOLD_CYC` cycles after that. The bench samples on falling edges, starting with the first falling edge after the accepting edge. It counts low-enable cycles, high-enable cycles and trailing busy cycles, and compares each count with its parameter. At every step it also checks that `lcd_rs` and `lcd_db` are unchanged. For dropped writes it watches the data lines and the enable line through the rest of the transaction and for several idle cycles afterwards.

// File: rtl/lcd_strobe_pkg.sv
package lcd_strobe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_strobe_pkg::*;
#(
  parameter int SETUP_CYC = 8,
  parameter int HIGH_CYC  = 46,
  parameter int HOLD_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic en_q
);
  localparam int MAXC = max3(SETUP_CYC, HIGH_CYC, HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d  = PH_SETUP;
        cnt_d = CW'(SETUP_CYC - 1);
      end
      PH_SETUP: if (cnt_q == '0) begin
        ph_d  = PH_HIGH;
        cnt_d = CW'(HIGH_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_HIGH: if (cnt_q == '0) begin
        ph_d  = PH_HOLD;
        cnt_d = CW'(HOLD_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_q == '0) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      en_q  <= (ph_d == PH_HIGH);
    end
  end

  assign busy = (ph_q != PH_IDLE);

  // Enable is only ever high inside a transaction.
  assert_en_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> busy);
  // The enable rises only after at least one setup cycle of busy.
  assert_setup_before_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(busy));
  // Hold phase follows every falling enable.
  assert_hold_after_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> busy);

endmodule

// File: rtl/lcd_bus_latch.sv
module lcd_bus_latch #(
  parameter int WORD_W = 16,
  parameter int DB_W   = 8,
  parameter int RS_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              rs_q,
  output logic [DB_W-1:0]   db_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 1'b0;
      db_q <= '0;
    end else if (load) begin
      rs_q <= word[RS_BIT];
      db_q <= word[DB_W-1:0];
    end
  end
endmodule

// File: rtl/lcd_strobe_ctrl.sv
module lcd_strobe_ctrl #(
  parameter int WORD_W    = 16,
  parameter int RS_BIT    = 8,
  parameter bit BUS8      = 1'b1,
  parameter int SETUP_CYC = 8,
  parameter int HIGH_CYC  = 46,
  parameter int HOLD_CYC  = 2,
  localparam int DB_W     = BUS8 ? 8 : 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              busy,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_en,
  output logic [DB_W-1:0]   lcd_db
);
  logic accept;

  assign wr_ready = ~busy;
  assign accept   = wr_valid & wr_ready;
  assign lcd_rw   = 1'b0;

  lcd_phase_seq #(
    .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .en_q(lcd_en)
  );

  lcd_bus_latch #(
    .WORD_W(WORD_W), .DB_W(DB_W), .RS_BIT(RS_BIT)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load(accept), .word(wr_data),
    .rs_q(lcd_rs), .db_q(lcd_db)
  );

  // An accepted word starts a transaction with the enable still low.
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (busy && !lcd_en));
  // Panel bus lines do not move within a transaction.
  assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lcd_db) && $stable(lcd_rs)));
  // A word offered during busy leaves the bus lines alone.
  assert_drop_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> ($stable(lcd_db) && $stable(lcd_rs)));

endmodule

// File: tb/test_lcd_strobe_ctrl.sv
`timescale 1ns/1ps
module test_lcd_strobe_ctrl;
  localparam int S = 8, H = 46, D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        v8 = 1'b0, v4 = 1'b0;
  logic [15:0] d8 = '0, d4 = '0;
  logic        rdy8, busy8, rs8, rw8, en8;
  logic [7:0]  db8;
  logic        rdy4, busy4, rs4, rw4, en4;
  logic [3:0]  db4;

  int checks = 0, failures = 0;

  lcd_strobe_ctrl #(.BUS8(1'b1), .SETUP_CYC(S), .HIGH_CYC(H), .HOLD_CYC(D)) i_lcd_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(v8), .wr_data(d8), .wr_ready(rdy8),
    .busy(busy8), .lcd_rs(rs8), .lcd_rw(rw8), .lcd_en(en8), .lcd_db(db8));

  lcd_strobe_ctrl #(.BUS8(1'b0), .SETUP_CYC(S), .HIGH_CYC(H), .HOLD_CYC(D)) i_lcd_strobe_ctrl_nib (
    .clk(clk), .rst_n(rst_n), .wr_valid(v4), .wr_data(d4), .wr_ready(rdy4),
    .busy(busy4), .lcd_rs(rs4), .lcd_rw(rw4), .lcd_en(en4), .lcd_db(db4));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one word for one edge on the 8-bit instance; returns at next negedge.
  task automatic put8(input logic [15:0] w);
    d8 = w; v8 = 1'b1;
    @(posedge clk); @(negedge clk);
    v8 = 1'b0;
  endtask

  task automatic put4(input logic [15:0] w);
    d4 = w; v4 = 1'b1;
    @(posedge clk); @(negedge clk);
    v4 = 1'b0;
  endtask

  // Measure phases from first negedge after accept; also flags bus movement.
  task automatic measure8(output int s, output int h, output int d, output int moved);
    logic [7:0] db0; logic rs0;
    s = 0; h = 0; d = 0; moved = 0;
    db0 = db8; rs0 = rs8;
    while (!en8 && busy8 && s < 500) begin s++; @(negedge clk);
      if (db8 != db0 || rs8 != rs0) moved = 1; end
    while (en8 && h < 500) begin h++; @(negedge clk);
      if (busy8 && (db8 != db0 || rs8 != rs0)) moved = 1; end
    while (busy8 && !en8 && d < 500) begin d++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 en", en8, 0); chk("R1 rs", rs8, 0); chk("R1 busy", busy8, 0);
    chk("R1 db", db8, 0); chk("R1 ready", rdy8, 1); chk("R9 rw", rw8, 0);
  endtask

  task automatic t_data_write();
    int s, h, d, mv;
    put8(16'h0141);
    chk("R2 busy", busy8, 1); chk("R2 ready", rdy8, 0);
    chk("R3 rs data", rs8, 1); chk("R4 db", db8, 8'h41);
    measure8(s, h, d, mv);
    chk("R5 setup", s, S); chk("R6 high", h, H); chk("R7 hold", d, D);
    chk("R7 stable", mv, 0); chk("R7 keep db", db8, 8'h41);
    chk("R9 rw", rw8, 0);
  endtask

  task automatic t_cmd_write();
    int s, h, d, mv;
    put8(16'h0001);
    chk("R3 rs cmd", rs8, 0); chk("R4 db cmd", db8, 8'h01);
    measure8(s, h, d, mv);
    chk("R5 setup cmd", s, S); chk("R6 high cmd", h, H); chk("R7 hold cmd", d, D);
  endtask

  task automatic t_upper_ignored();
    int s, h, d, mv;
    put8(16'hFEA5);  // bit 8 = 0, upper bits set
    chk("R4 upper db", db8, 8'hA5); chk("R4 upper rs", rs8, 0);
    measure8(s, h, d, mv);
    put8(16'h01C3);
    chk("R4 only rs bit", rs8, 1); chk("R4 db2", db8, 8'hC3);
    measure8(s, h, d, mv);
  endtask

  task automatic t_drop_busy();
    int s, h, d, mv, extra;
    put8(16'h0033);
    repeat (3) @(negedge clk);
    chk("R8 ready low", rdy8, 0);
    put8(16'h01CC);
    chk("R8 db kept", db8, 8'h33); chk("R8 rs kept", rs8, 0);
    measure8(s, h, d, mv);
    chk("R8 high once", h, H); chk("R8 stable", mv, 0);
    extra = 0;
    repeat (8) begin @(negedge clk); if (busy8 || en8) extra++; end
    chk("R8 no second strobe", extra, 0); chk("R8 db final", db8, 8'h33);
  endtask

  task automatic t_back_to_back();
    int s, h, d, mv;
    put8(16'h0155);
    measure8(s, h, d, mv);
    chk("R2 ready after", rdy8, 1);
    put8(16'h00AA);
    chk("R2 b2b busy", busy8, 1); chk("R2 b2b db", db8, 8'hAA);
    measure8(s, h, d, mv);
    chk("R5 b2b setup", s, S); chk("R6 b2b high", h, H);
  endtask

  task automatic t_nibble();
    int s, h;
    put4(16'h01B7);
    chk("R10 hi? db", db4, 4'h7); chk("R10 rs", rs4, 1);
    s = 0; h = 0;
    while (!en4 && busy4 && s < 500) begin s++; @(negedge clk); end
    while (en4 && h < 500) begin h++; @(negedge clk); end
    chk("R10 setup", s, S); chk("R10 high", h, H);
    while (busy4) @(negedge clk);
    put4(16'h000E);
    chk("R10 second nibble", db4, 4'hE); chk("R10 rs cmd", rs4, 0);
    chk("R9 rw nib", rw4, 0);
    while (busy4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_write();
    t_cmd_write();
    t_upper_ignored();
    t_drop_busy();
    t_back_to_back();
    t_nibble();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule